// File: doc/BRIEF.md
# Start-up Sequencer with Selectable Sample-Clock Divider

This block sits next to an analog front end and does two jobs. It derives the converter sample clock from the sensor clock. The divide ratio is 2 or 3, chosen by a mode input. In divide-by-3 mode the clock is high for one input cycle out of three.

It also walks the front end through its power-up order. After a synchronous reset, the block waits a fixed guard interval before it will accept the "configuration loaded" strobe. Once it takes that strobe, it waits a programmable number of input-clock cycles for external capacitors to charge. It then holds a calibration-active flag for a fixed number of sample-clock periods. When calibration ends, the flag drops and a ready output rises on the same edge. Downstream logic uses the ready output to enable its sample pulses.

The divide mode is captured while reset is held, so the ratio cannot change during a run. Reset is honoured at any point and restarts the whole order.

Top module: `pwrup_seq_top`

## Requirements
- R1: With the mode captured as divide-by-2, `adclk` is low throughout reset. After the k-th rising `clk_in` edge following reset release, `adclk` is 1 exactly when k is even. This gives period 2 and one high cycle.
- R2: With the mode captured as divide-by-3, after the k-th rising edge following release `adclk` is 1 exactly when k is a multiple of 3. This gives period 3 and one high cycle per period.
- R3: `div3_mode` is sampled only while `rst` is high. Changes to it after release have no effect on `adclk`.
- R4: While `rst` is high, `adclk`, `cal_busy` and `seq_ready` are all 0.
- R5: A `cfg_loaded` pulse sampled at any of the first GAP_CLKS (default 6) rising edges after reset release is ignored, and calibration never starts from it.
- R6: A `cfg_loaded` pulse accepted at edge t makes `cal_busy` rise exactly at edge t+L. L is `settle_cycles` captured at edge t, and a value of 0 is treated as 1.
- R7: While `cal_busy` is high, exactly CAL_PERIODS (default 40000) high cycles of `adclk` occur, counted in either divide mode.
- R8: `seq_ready` rises on the same edge on which `cal_busy` falls. It stays high until the next reset. The two outputs are never high together.
- R9: A reset asserted mid-sequence clears `cal_busy` and `seq_ready` at that edge. A fresh `cfg_loaded` pulse is then required before calibration starts again.
- R10: `cfg_loaded` pulses during settling, calibration or ready have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Sensor clock; all logic is clocked on its rising edge |
| rst | input | 1 | Synchronous active-high reset; also captures the divide mode |
| div3_mode | input | 1 | 1 selects divide-by-3, 0 selects divide-by-2 |
| cfg_loaded | input | 1 | One-cycle strobe: register loading finished |
| settle_cycles | input | SETTLE_W | Settling wait length in `clk_in` cycles |
| adclk | output | 1 | Registered divided sample clock |
| cal_busy | output | 1 | High during the offset-calibration period |
| seq_ready | output | 1 | High once the start-up order has completed |

## Verification
Every output is a single register stage, so each result appears one edge after the edge that decides it. The divider's value after the k-th edge is fixed by k modulo the ratio. The calibration flag rises exactly L edges after the edge that samples the configuration strobe, and ready appears on the edge where calibration ends. The bench drives inputs and samples outputs on falling edges. It counts falling edges from a known reference edge, so each check lands in the cycle just after the edge that owns the result. This includes the cycle just before that edge for the settle boundary. Sample-clock periods during calibration are counted by a falling-edge monitor and compared with the parameter once ready has risen.

// File: rtl/pwrup_seq_pkg.sv
`timescale 1ns/1ps
package pwrup_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_WAIT_CFG = 3'd1,
    ST_SETTLE   = 3'd2,
    ST_CALIB    = 3'd3,
    ST_READY    = 3'd4
  } seq_state_t;

  // Settling length with zero promoted to one cycle.
  function automatic logic [31:0] min_one(input logic [31:0] v);
    return (v == 32'd0) ? 32'd1 : v;
  endfunction

endpackage

// File: rtl/step_counter.sv
`timescale 1ns/1ps
module step_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst || clr)
      count <= '0;
    else if (inc)
      count <= count + 1'b1;
  end

  // Callers bound their counts below the counter range (R6, R7).
  p_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr) |=> (count != '0));

endmodule

// File: rtl/adclk_divider.sv
`timescale 1ns/1ps
module adclk_divider #(
  parameter int RATIO_LO = 2,
  parameter int RATIO_HI = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic div_hi,
  output logic adclk
);

  localparam int PW = $clog2(RATIO_HI);

  logic          mode_hi_q;
  logic [PW-1:0] phase_q;
  logic [PW-1:0] phase_last;
  logic [PW-1:0] phase_nxt;

  assign phase_last = mode_hi_q ? PW'(RATIO_HI - 1) : PW'(RATIO_LO - 1);
  assign phase_nxt  = (phase_q == phase_last) ? '0 : phase_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_hi_q <= div_hi;       // R3: ratio latched only in reset
      phase_q   <= '0;
      adclk     <= 1'b0;         // R4
    end else begin
      phase_q   <= phase_nxt;
      adclk     <= (phase_nxt == '0);
    end
  end

  p_mode_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(mode_hi_q));

  p_one_high_r1: assert property (@(posedge clk) disable iff (rst)
    adclk |=> !adclk);

  p_hi_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (adclk && mode_hi_q) |=> (!adclk ##1 !adclk));

  p_phase_range_r2: assert property (@(posedge clk) disable iff (rst)
    phase_q <= phase_last);

endmodule

// File: rtl/startup_fsm.sv
`timescale 1ns/1ps
module startup_fsm
  import pwrup_seq_pkg::*;
#(
  parameter int GAP_CLKS    = 6,
  parameter int CAL_PERIODS = 40000,
  parameter int SETTLE_W    = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_loaded,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                sample_hi,
  output logic                cal_busy,
  output logic                seq_ready
);

  localparam int CW = $clog2(CAL_PERIODS + 1);

  seq_state_t          st_q, st_nxt;
  logic [SETTLE_W-1:0] len_q;
  logic [SETTLE_W-1:0] ph_cnt;
  logic [CW-1:0]       cal_cnt;
  logic                ph_clr, ph_inc, cal_clr, cal_inc, len_load;

  step_counter #(.W(SETTLE_W)) u_phase_cnt (
    .clk(clk), .rst(rst), .clr(ph_clr), .inc(ph_inc), .count(ph_cnt)
  );

  step_counter #(.W(CW)) u_cal_cnt (
    .clk(clk), .rst(rst), .clr(cal_clr), .inc(cal_inc), .count(cal_cnt)
  );

  always_comb begin
    st_nxt   = st_q;
    ph_clr   = 1'b0;
    ph_inc   = 1'b0;
    cal_clr  = 1'b0;
    cal_inc  = 1'b0;
    len_load = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (ph_cnt == SETTLE_W'(GAP_CLKS - 1)) begin
          st_nxt = ST_WAIT_CFG;
          ph_clr = 1'b1;
        end else begin
          ph_inc = 1'b1;
        end
      end
      ST_WAIT_CFG: begin
        if (cfg_loaded) begin
          st_nxt   = ST_SETTLE;
          ph_clr   = 1'b1;
          len_load = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (ph_cnt == len_q - 1'b1) begin
          st_nxt  = ST_CALIB;
          cal_clr = 1'b1;
        end else begin
          ph_inc = 1'b1;
        end
      end
      ST_CALIB: begin
        if (sample_hi) begin
          if (cal_cnt == CW'(CAL_PERIODS - 1))
            st_nxt = ST_READY;
          else
            cal_inc = 1'b1;
        end
      end
      ST_READY: st_nxt = ST_READY;
      default:  st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      len_q     <= SETTLE_W'(1);
      cal_busy  <= 1'b0;
      seq_ready <= 1'b0;
    end else begin
      st_q      <= st_nxt;
      cal_busy  <= (st_nxt == ST_CALIB);
      seq_ready <= (st_nxt == ST_READY);
      if (len_load)
        len_q <= SETTLE_W'(min_one(32'(settle_cycles)));
    end
  end

  p_no_early_cfg_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE) |=> (st_q != ST_SETTLE));

  p_settle_bound_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SETTLE) |-> (ph_cnt < len_q));

  p_cal_bound_r7: assert property (@(posedge clk) disable iff (rst)
    cal_cnt < CW'(CAL_PERIODS));

  p_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    !(cal_busy && seq_ready));

  p_ready_holds_r8: assert property (@(posedge clk) disable iff (rst)
    seq_ready |=> seq_ready);

  p_ready_from_cal_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(seq_ready) |-> $past(cal_busy));

  p_cfg_late_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_CALIB) |=> (st_q == ST_CALIB || st_q == ST_READY));

endmodule

// File: rtl/pwrup_seq_top.sv
`timescale 1ns/1ps
module pwrup_seq_top #(
  parameter int GAP_CLKS    = 6,
  parameter int CAL_PERIODS = 40000,
  parameter int SETTLE_W    = 24
) (
  input  logic                clk_in,
  input  logic                rst,
  input  logic                div3_mode,
  input  logic                cfg_loaded,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic                adclk,
  output logic                cal_busy,
  output logic                seq_ready
);

  adclk_divider #(.RATIO_LO(2), .RATIO_HI(3)) u_div (
    .clk(clk_in), .rst(rst), .div_hi(div3_mode), .adclk(adclk)
  );

  startup_fsm #(
    .GAP_CLKS(GAP_CLKS), .CAL_PERIODS(CAL_PERIODS), .SETTLE_W(SETTLE_W)
  ) u_fsm (
    .clk(clk_in), .rst(rst), .cfg_loaded(cfg_loaded),
    .settle_cycles(settle_cycles), .sample_hi(adclk),
    .cal_busy(cal_busy), .seq_ready(seq_ready)
  );

  p_reset_quiet_r4: assert property (@(posedge clk_in)
    $past(rst) |-> (!cal_busy && !seq_ready));

endmodule

// File: tb/sim_pwrup_seq_top.sv
`timescale 1ns/1ps
module sim_pwrup_seq_top;

  localparam int GAP = 6;
  localparam int CAL = 20;
  localparam int SW  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          div3 = 1'b0;
  logic          cfg = 1'b0;
  logic [SW-1:0] slen = '0;
  logic          adclk, cal_busy, seq_ready;

  int total = 0;
  int bad   = 0;
  int rises = 0;
  bit done  = 0;
  logic last_adclk = 1'b0;

  always #4 clk = ~clk;

  pwrup_seq_top #(.GAP_CLKS(GAP), .CAL_PERIODS(CAL), .SETTLE_W(SW)) u0 (
    .clk_in(clk), .rst(rst), .div3_mode(div3), .cfg_loaded(cfg),
    .settle_cycles(slen), .adclk(adclk), .cal_busy(cal_busy),
    .seq_ready(seq_ready)
  );

  always @(negedge clk) begin
    if (cal_busy && adclk && !last_adclk) rises = rises + 1;
    last_adclk <= adclk;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply_reset(input bit m3);
    @(negedge clk);
    rst = 1'b1; div3 = m3; cfg = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 adclk in reset", adclk, 0);
    chk("R4 cal_busy in reset", cal_busy, 0);
    chk("R4 seq_ready in reset", seq_ready, 0);
    rst = 1'b0;
  endtask

  task automatic pulse_cfg();
    cfg = 1'b1;
    @(negedge clk);
    cfg = 1'b0;
  endtask

  // R1 / R2 / R3: clock pattern after release, mode input flipped
  task automatic t_divider(input bit m3, input int n);
    apply_reset(m3);
    div3 = ~m3;
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      chk(m3 ? "R2 R3 div3 pattern" : "R1 R3 div2 pattern",
          adclk, (k % n == 0) ? 1 : 0);
    end
  endtask

  // R5..R8, R10: full start-up order
  task automatic t_sequence(input bit m3, input int len);
    int leff, base, guard;
    leff = (len == 0) ? 1 : len;
    slen = SW'(len);
    apply_reset(m3);
    repeat (GAP - 1) @(negedge clk);
    pulse_cfg();                       // sampled at edge GAP: ignored
    for (int i = 0; i < leff + 4; i++) begin
      @(negedge clk);
      if (i == leff + 3) chk("R5 early cfg ignored", cal_busy, 0);
    end
    base = rises;
    pulse_cfg();
    repeat (leff - 1) @(negedge clk);
    chk("R6 cal before settle end", cal_busy, 0);
    @(negedge clk);
    chk("R6 cal at settle end", cal_busy, 1);
    pulse_cfg();                       // R10: during calibration
    guard = 0;
    while (cal_busy && guard < 1000) begin
      chk("R8 not both", seq_ready, 0);
      @(negedge clk);
      guard++;
    end
    chk("R8 ready with cal fall", seq_ready, 1);
    @(negedge clk);
    chk("R7 sample periods in cal", rises - base, CAL);
    pulse_cfg();                       // R10: in ready
    repeat (8) @(negedge clk);
    chk("R8 R10 ready held", seq_ready, 1);
    chk("R10 cal stays low", cal_busy, 0);
  endtask

  // R9: reset during calibration
  task automatic t_mid_reset();
    slen = SW'(3);
    apply_reset(1'b0);
    repeat (GAP) @(negedge clk);
    pulse_cfg();
    repeat (4) @(negedge clk);
    chk("R9 cal started", cal_busy, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9 cal cleared", cal_busy, 0);
    chk("R9 ready cleared", seq_ready, 0);
    repeat (40) @(negedge clk);
    chk("R9 no restart without cfg", cal_busy + seq_ready, 0);
    pulse_cfg();
    repeat (2) @(negedge clk);
    chk("R9 settle before cal", cal_busy, 0);
    @(negedge clk);
    chk("R9 cal after new cfg", cal_busy, 1);
  endtask

  initial begin
    t_divider(1'b0, 2);
    t_divider(1'b1, 3);
    t_sequence(1'b0, 5);
    t_sequence(1'b1, 0);
    t_sequence(1'b1, 2);
    t_mid_reset();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule